// File: doc/BRIEF.md
# Bitwise Ternary Logic Unit

This unit applies one freely chosen three-input Boolean function to every bit position of three equally wide operand vectors. The function arrives as an 8-bit truth-table code alongside the operands. At each bit position the three operand bits together form a 3-bit index, and the result bit is the code bit at that index. All 256 three-input functions can therefore be expressed. This includes the ones that depend on only one or two operands, and none of them needs any special handling.

A request is accepted on any cycle with `in_valid` high. The result and `out_valid` come out of a register one clock later. An optional lane mask can be built in by parameter. When it is present, a bit position whose mask bit is 0 passes the first operand's bit through unchanged. The operand width is a parameter from 1 to 512 bits.

Top module: `tern_logic_unit`

## Requirements
- R1: For every bit position i, the result bit equals `func_code[{src_a[i], src_b[i], src_c[i]}]`. The index has `src_a` as bit 2 (MSB), `src_b` as bit 1 and `src_c` as bit 0 (LSB). This holds for all 256 code values.
- R2: Code 0xB0 yields `a & (~b | c)` on every bit.
- R3: Code 0x80 yields the three-input AND, code 0xFE the three-input OR, and code 0x96 the three-input XOR.
- R4: Codes that ignore operands need no special case. Code 0xF0 returns `src_a`, code 0xCC returns `src_b`, and code 0xAA returns `src_c`, whatever the other operands hold.
- R5: After a cycle with `in_valid` high, `out_valid` is high on the next cycle and `out_result` holds the function of that cycle's inputs.
- R6: After a cycle with `in_valid` low, `out_valid` is low on the next cycle and `out_result` keeps its previous value, even if the operands change.
- R7: A synchronous reset (`rst` high at a clock edge) drives `out_valid` low on the next cycle, even when `in_valid` is high.
- R8: With `MASK_EN` = 1, each bit position whose `lane_mask` bit is 0 outputs the `src_a` bit of the accepted cycle. Each position whose mask bit is 1 outputs the function result.
- R9: With `MASK_EN` = 0, `lane_mask` has no effect. Every bit position outputs the function result.
- R10: `WIDTH` may be any value from 1 to 512. A value outside that range stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept the operands and code on this cycle |
| func_code | input | 8 | Truth-table code of the three-input function |
| src_a | input | WIDTH | First operand; index MSB; kept in masked lanes |
| src_b | input | WIDTH | Second operand; middle index bit |
| src_c | input | WIDTH | Third operand; index LSB |
| lane_mask | input | WIDTH | Per-lane enable for the function (used only when MASK_EN = 1) |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | WIDTH | Registered result vector |

## Verification
The clocked properties assume that `in_valid`, `func_code`, the operands and the mask are stable around the rising edge. They also assume that reset is held for at least one edge before the first request. They compare the output one cycle later against the inputs sampled on the accepting edge. The bench drives every input on the falling edge and reads outputs on the following falling edge, so each sample lies a full half period away from the edge that moves the register. Reset is raised only on a falling edge, so the properties that depend on reset never see it change at the sampling edge.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

   // width of the truth-table code: one bit per combination of three inputs
   localparam int unsigned CODE_W   = 8;
   localparam int unsigned INDEX_W  = 3;
   localparam int unsigned MAX_LANES = 512;

   typedef logic [CODE_W-1:0] func_code_t;

endpackage

// File: rtl/tlu_lane_lut.sv
// Per-lane 8:1 lookup of the function code.
module tlu_lane_lut #(
   parameter int unsigned WIDTH = 512
) (
   input  tlu_pkg::func_code_t code,
   input  logic [WIDTH-1:0]    op_a,
   input  logic [WIDTH-1:0]    op_b,
   input  logic [WIDTH-1:0]    op_c,
   output logic [WIDTH-1:0]    lut_out
);
   import tlu_pkg::*;

   for (genvar g = 0; g < WIDTH; g++) begin : g_lane
      logic [INDEX_W-1:0] sel;
      // first operand carries the most significant index bit
      assign sel        = {op_a[g], op_b[g], op_c[g]};
      assign lut_out[g] = code[sel];
   end

endmodule

// File: rtl/tlu_mask_merge.sv
// Optional per-lane write mask: masked lanes keep the first operand.
module tlu_mask_merge #(
   parameter int unsigned WIDTH   = 512,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic [WIDTH-1:0] func_res,
   input  logic [WIDTH-1:0] keep_val,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] merged
);

   if (MASK_EN) begin : g_masked
      for (genvar g = 0; g < WIDTH; g++) begin : g_lane
         assign merged[g] = mask[g] ? func_res[g] : keep_val[g];
      end
   end else begin : g_plain
      logic unused_mask;
      assign unused_mask = ^{mask, keep_val};
      assign merged      = func_res;
   end

endmodule

// File: rtl/tlu_out_reg.sv
// Result register and valid flag.
module tlu_out_reg #(
   parameter int unsigned WIDTH = 512
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic             q_valid,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q_valid <= 1'b0;
      else     q_valid <= load;
   end

   // data path is not reset: only the valid flag qualifies it
   always_ff @(posedge clk) begin
      if (load && !rst) q <= d;
   end

   // R7
   reset_clears_valid_chk: assert property (@(posedge clk)
      rst |=> !q_valid);

   // R6
   idle_holds_data_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

endmodule

// File: rtl/tern_logic_unit.sv
// Bitwise ternary logic unit: any 3-input function, applied per bit.
module tern_logic_unit #(
   parameter int unsigned WIDTH   = 512,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [7:0]       func_code,
   input  logic [WIDTH-1:0] src_a,
   input  logic [WIDTH-1:0] src_b,
   input  logic [WIDTH-1:0] src_c,
   input  logic [WIDTH-1:0] lane_mask,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_result
);
   import tlu_pkg::*;

   localparam logic [WIDTH-1:0] ALL_ZERO = '0;

   // R10
   if (WIDTH < 1 || WIDTH > MAX_LANES) begin : g_bad_width
      $error("tern_logic_unit: WIDTH %0d outside 1..%0d", WIDTH, MAX_LANES);
   end

   func_code_t       code_q;
   logic [WIDTH-1:0] lut_res;
   logic [WIDTH-1:0] merged_res;

   assign code_q = func_code;

   tlu_lane_lut #(.WIDTH(WIDTH)) u_lut (
      .code    (code_q),
      .op_a    (src_a),
      .op_b    (src_b),
      .op_c    (src_c),
      .lut_out (lut_res)
   );

   tlu_mask_merge #(.WIDTH(WIDTH), .MASK_EN(MASK_EN)) u_merge (
      .func_res (lut_res),
      .keep_val (src_a),
      .mask     (lane_mask),
      .merged   (merged_res)
   );

   tlu_out_reg #(.WIDTH(WIDTH)) u_oreg (
      .clk     (clk),
      .rst     (rst),
      .load    (in_valid),
      .d       (merged_res),
      .q_valid (out_valid),
      .q       (out_result)
   );

   // R5
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R6
   idle_to_invalid_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R1
   const_zero_code_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && func_code == 8'h00 && lane_mask == ~ALL_ZERO) |=>
         out_result == ALL_ZERO);

   // R4
   pass_a_code_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && func_code == 8'hF0) |=> out_result == $past(src_a));

   if (MASK_EN) begin : g_mask_chk
      // R8
      masked_lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
         in_valid |=>
            ((out_result ^ $past(src_a)) & ~$past(lane_mask)) == ALL_ZERO);
   end else begin : g_nomask_chk
      // R9
      mask_ignored_chk: assert property (@(posedge clk) disable iff (rst)
         (in_valid && func_code == 8'hFF) |=> out_result == ~ALL_ZERO);
   end

endmodule

// File: tb/tb_tern_logic_unit.sv
module tb_tern_logic_unit;

   localparam int W  = 64;
   localparam int WW = 512;
   localparam int NROW = 9;

   localparam logic [7:0] T_CODE [NROW] = '{
      8'hB0, 8'h80, 8'hFE, 8'h96, 8'hB0, 8'hB0, 8'h96, 8'hF0, 8'h00 };
   localparam logic [W-1:0] T_A [NROW] = '{
      {8{8'hF0}}, {8{8'hF0}}, {8{8'hF0}}, {8{8'hF0}}, {W{1'b1}},
      {W{1'b1}}, {W{1'b1}}, 64'h0123456789ABCDEF, {W{1'b1}} };
   localparam logic [W-1:0] T_B [NROW] = '{
      {8{8'hCC}}, {8{8'hCC}}, {8{8'hCC}}, {8{8'hCC}}, {W{1'b0}},
      {W{1'b1}}, {W{1'b1}}, {W{1'b1}}, 64'h5A5A5A5A5A5A5A5A };
   localparam logic [W-1:0] T_C [NROW] = '{
      {8{8'hAA}}, {8{8'hAA}}, {8{8'hAA}}, {8{8'hAA}}, {W{1'b0}},
      {W{1'b0}}, {W{1'b1}}, {W{1'b0}}, 64'h3C3C3C3C3C3C3C3C };
   localparam logic [W-1:0] T_M [NROW] = '{
      {W{1'b1}}, {W{1'b1}}, {W{1'b1}}, {W{1'b1}}, {W{1'b1}},
      {W{1'b1}}, {W{1'b1}}, {W{1'b1}}, {8{8'h0F}} };
   localparam logic [W-1:0] T_E [NROW] = '{
      {8{8'hB0}}, {8{8'h80}}, {8{8'hFE}}, {8{8'h96}}, {W{1'b1}},
      {W{1'b0}}, {W{1'b1}}, 64'h0123456789ABCDEF, {8{8'hF0}} };

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [7:0]    code;
   logic [W-1:0]  a, b, c, m;
   logic          ov, ov_w;
   logic [W-1:0]  res;
   logic [WW-1:0] res_w;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   tern_logic_unit #(.WIDTH(W), .MASK_EN(1'b1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(code),
      .src_a(a), .src_b(b), .src_c(c), .lane_mask(m),
      .out_valid(ov), .out_result(res));

   // unmasked variant at full width, fed with replicated operands
   tern_logic_unit #(.WIDTH(WW), .MASK_EN(1'b0)) dut_nm (
      .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(code),
      .src_a({8{a}}), .src_b({8{b}}), .src_c({8{c}}), .lane_mask({8{m}}),
      .out_valid(ov_w), .out_result(res_w));

   // sum of minterms: each set code bit k contributes the lanes whose
   // (a,b,c) combination equals k, with a as weight 4 and c as weight 1
   function automatic logic [W-1:0] model(input logic [7:0] f,
                                          input logic [W-1:0] x, y, z);
      logic [W-1:0] acc = '0;
      for (int k = 0; k < 8; k++) begin
         if (f[k])
            acc |= ((k & 4) != 0 ? x : ~x) & ((k & 2) != 0 ? y : ~y) &
                   ((k & 1) != 0 ? z : ~z);
      end
      return acc;
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] f, input logic [W-1:0] x, y, z,
                        input logic [W-1:0] msk);
      @(negedge clk);
      in_valid = 1'b1; code = f; a = x; b = y; c = z; m = msk;
      @(negedge clk);
   endtask

   task automatic go_idle();
      in_valid = 1'b0;
   endtask

   logic [W-1:0] ra, rb, rc, rm, exp_v, held;

   initial begin
      rst = 1'b1; in_valid = 1'b0; code = '0; a = '0; b = '0; c = '0; m = '0;
      repeat (3) @(negedge clk);
      // R7 reset state
      check(ov == 1'b0 && ov_w == 1'b0, "R7 reset", WW'(ov), '0);
      rst = 1'b0;
      @(negedge clk);

      // table walk (R1 R2 R3 R4 R8)
      for (int i = 0; i < NROW; i++) begin
         drive(T_CODE[i], T_A[i], T_B[i], T_C[i], T_M[i]);
         check(ov == 1'b1 && res == T_E[i],
               $sformatf("R1/R2/R3/R4/R8 row %0d", i), WW'(res), WW'(T_E[i]));
      end

      // full sweep of all 256 codes, two operand sets, masked and unmasked
      ra = 64'h9E3779B97F4A7C15; rb = 64'hC2B2AE3D27D4EB4F;
      rc = 64'h165667B19E3779F9; rm = 64'hF0F0A5A5FFFF0001;
      for (int f = 0; f < 256; f++) begin
         drive(8'(f), ra, rb, rc, {W{1'b1}});
         exp_v = model(8'(f), ra, rb, rc);
         check(ov && res == exp_v, $sformatf("R1 code %02h", f),
               WW'(res), WW'(exp_v));
         // R9 R10: 512-lane unmasked instance gets the function everywhere
         check(ov_w && res_w == {8{exp_v}}, $sformatf("R9 R10 code %02h", f),
               res_w, {8{exp_v}});
         drive(8'(f), rc, ra, rb, rm);
         exp_v = (model(8'(f), rc, ra, rb) & rm) | (rc & ~rm);
         check(res == exp_v, $sformatf("R8 code %02h", f),
               WW'(res), WW'(exp_v));
         // R9: mask zeros do not affect the unmasked instance
         check(res_w == {8{model(8'(f), rc, ra, rb)}},
               $sformatf("R9 code %02h", f), res_w,
               {8{model(8'(f), rc, ra, rb)}});
         ra = {ra[62:0], ra[63] ^ ra[61]} ^ rb;
         rb = rb ^ {rc[31:0], rc[63:32]};
         rc = {rc[0], rc[63:1]} + 64'd7;
      end

      // R4: 0xCC and 0xAA select single operands
      drive(8'hCC, ra, rb, rc, {W{1'b1}});
      check(res == rb, "R4 code CC", WW'(res), WW'(rb));
      drive(8'hAA, ra, rb, rc, {W{1'b1}});
      check(res == rc, "R4 code AA", WW'(res), WW'(rc));

      // R5 then R6: idle cycle drops valid and holds data
      drive(8'h96, ra, rb, rc, {W{1'b1}});
      held = res;
      check(ov == 1'b1, "R5 valid", WW'(ov), 1);
      go_idle();
      a = ~ra; code = 8'hFF;
      @(negedge clk);
      check(ov == 1'b0, "R6 valid drop", WW'(ov), 0);
      check(res == held, "R6 hold", WW'(res), WW'(held));

      // R7: reset wins over a request
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      check(ov == 1'b0 && ov_w == 1'b0, "R7 reset over valid", WW'(ov), 0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check(ov == 1'b0, "R7 after reset idle", WW'(ov), 0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog act=timeout exp=done");
         end
      join_any
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule